// File: doc/BRIEF.md
# Frame-Aligned Parameter Safe-Load Controller

This block lets a host change a group of DSP coefficients in one step, so that the running audio never sees half of an update. The host loads up to five 32-bit words into staging registers over a byte-wide register bus. It then writes a destination pointer and finally a word count into a trigger register. The controller takes a private copy of the staged words and the pointer, holds the request, and writes the words into parameter RAM only once the next audio frame begins. The words go in back to back, one per clock, at ascending addresses.

The destination pointer is stored one below the real destination, so the first word lands at the stored value plus one. Addresses wrap around the end of parameter RAM. Every register on the host bus is four bytes wide and is written one byte at a time, with the most significant byte on lane 0. Padding a short payload to whole words is the host's task. A trigger that arrives while a request is still pending or copying is dropped and raises a sticky error flag.

Top module: `safeload_ctrl`

## Requirements
- R1: While reset is held low at a clock edge, busy, err_flag and ram_we are all low after that edge.
- R2: Register index 1 to 5 are the staging words, in order; index 6 is the destination pointer and index 7 the trigger. Byte lane 0 carries bits 31:24 of a register and lane 3 carries bits 7:0. Writing lane 3 of the trigger register completes a trigger, using the value of all four lanes.
- R3: A trigger whose 32-bit value is 1 to 5, written while idle, raises busy in the next cycle. No RAM write happens until a frame strobe is seen.
- R4: The first frame_start that is high at a clock edge while a request is pending starts the copy. ram_we is then high for exactly count consecutive cycles beginning after that edge, and low at all other times.
- R5: The first written address is (pointer + 1) mod 1024, using the low 10 bits of the pointer. Each further word goes to the next address mod 1024.
- R6: The i-th written word (counting from 0) equals staging register 1+i as it stood when the trigger was written.
- R7: Writes to staging or pointer registers after a trigger do not change the request already accepted.
- R8: busy falls at the same edge that takes the last word, so it is low in the cycle after the final write.
- R9: A trigger value of 0, or of anything above 5 (upper bytes included), leaves busy low, writes nothing and leaves err_flag unchanged.
- R10: A trigger written while busy is ignored and sets err_flag. err_flag stays high until reset.
- R11: A frame strobe while idle causes no RAM write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_wr | input | 1 | Host byte-write strobe |
| host_reg | input | 3 | Register index (1-5 staging, 6 pointer, 7 trigger) |
| host_lane | input | 2 | Byte lane within the register; 0 is most significant |
| host_byte | input | 8 | Byte to write |
| frame_start | input | 1 | Audio frame boundary strobe |
| busy | output | 1 | A request is pending or being copied |
| err_flag | output | 1 | Sticky flag: a trigger arrived while busy |
| ram_we | output | 1 | Parameter RAM write enable |
| ram_addr | output | 10 | Parameter RAM word address |
| ram_wdata | output | 32 | Parameter RAM write data |

## Verification
Directed cases cover the single-word, full five-word and wrap-around bursts. The wrap cases use a pointer of 1022 and a pointer of 1023, which separates an off-by-one in the pointer adjustment from a missing modulo. Invalid counts include a value whose low bits alone would look legal, which shows whether the count decode checks all four bytes. Other cases cover a second trigger and staging rewrites issued between trigger and frame, which tell whether the request is snapshotted or read live. Random bursts with random pointers, data, counts and frame delays are compared word by word, in address and data, against a bench model of the expected writes.

// File: rtl/sload_pkg.sv
// Shared types for the safe-load controller.
package sload_pkg;
    // Request sequencer states: idle, waiting for a frame edge, copying words.
    typedef enum logic [1:0] {
        SL_IDLE = 2'd0,
        SL_PEND = 2'd1,
        SL_COPY = 2'd2
    } sl_state_e;
endpackage

// File: rtl/sload_regfile.sv
// Host-side register bank.
// Holds WORDS staging words, the destination pointer (only its low AW bits)
// and the upper bytes of the trigger value. Registers are DW bits wide and
// written one byte per cycle; lane 0 is the most significant byte.
// Assumes AW <= DW. Writing the last lane of the trigger register yields a
// one-cycle fire pulse together with the full trigger value.
module sload_regfile #(
    parameter int WORDS = 5,
    parameter int DW    = 32,
    parameter int AW    = 10
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            wr_en,
    input  logic [$clog2(WORDS+3)-1:0]      wr_reg,
    input  logic [$clog2(DW/8)-1:0]         wr_lane,
    input  logic [7:0]                      wr_byte,
    output logic [WORDS*DW-1:0]             stage_flat,
    output logic [AW-1:0]                   pointer,
    output logic                            trig_fire,
    output logic [DW-1:0]                   trig_value
);
    localparam int BYTES  = DW / 8;
    localparam int RW     = $clog2(WORDS + 3);
    localparam int LW     = $clog2(BYTES);
    localparam logic [RW-1:0] PTR_IDX  = RW'(WORDS + 1);
    localparam logic [RW-1:0] TRIG_IDX = RW'(WORDS + 2);

    logic [DW-9:0] trig_hold;

    // One register per staging word, one byte lane per generated process.
    for (genvar w = 0; w < WORDS; w++) begin : g_word
        for (genvar b = 0; b < BYTES; b++) begin : g_lane
            // Capture lane b of staging word w.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    stage_flat[w*DW + (BYTES-1-b)*8 +: 8] <= '0;
                else if (wr_en && wr_reg == RW'(w + 1) && wr_lane == LW'(b))
                    stage_flat[w*DW + (BYTES-1-b)*8 +: 8] <= wr_byte;
            end
        end
    end

    // Pointer: only the bits that address RAM are kept.
    for (genvar p = 0; p < AW; p++) begin : g_ptr
        // Capture pointer bit p from the lane that carries it.
        always_ff @(posedge clk) begin
            if (!rst_n)
                pointer[p] <= 1'b0;
            else if (wr_en && wr_reg == PTR_IDX && wr_lane == LW'(BYTES-1-p/8))
                pointer[p] <= wr_byte[p%8];
        end
    end

    // Upper trigger bytes wait here until the final lane completes the value.
    for (genvar t = 0; t < BYTES-1; t++) begin : g_trig
        // Capture trigger lane t.
        always_ff @(posedge clk) begin
            if (!rst_n)
                trig_hold[(BYTES-2-t)*8 +: 8] <= '0;
            else if (wr_en && wr_reg == TRIG_IDX && wr_lane == LW'(t))
                trig_hold[(BYTES-2-t)*8 +: 8] <= wr_byte;
        end
    end

    // Trigger fires on the least significant lane, carrying the whole value.
    always_comb begin
        trig_fire  = wr_en && (wr_reg == TRIG_IDX) && (wr_lane == LW'(BYTES-1));
        trig_value = {trig_hold, wr_byte};
    end
endmodule

// File: rtl/sload_seq.sv
// Request sequencer and commit buffer.
// Accepts a trigger while idle when its value lies in 1..WORDS, snapshots the
// staged words and the adjusted pointer, waits for a frame strobe, then drives
// one RAM write per cycle at ascending addresses that wrap modulo 2**AW.
// A trigger seen while not idle is dropped and sets a sticky error.
module sload_seq
    import sload_pkg::*;
#(
    parameter int WORDS = 5,
    parameter int DW    = 32,
    parameter int AW    = 10
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 trig_fire,
    input  logic [DW-1:0]        trig_value,
    input  logic [WORDS*DW-1:0]  stage_flat,
    input  logic [AW-1:0]        pointer,
    input  logic                 frame_start,
    output logic                 busy,
    output logic                 err_flag,
    output logic                 ram_we,
    output logic [AW-1:0]        ram_addr,
    output logic [DW-1:0]        ram_wdata
);
    localparam int CW = $clog2(WORDS + 1);

    sl_state_e        state_q;
    logic [CW-1:0]    count_q;
    logic [CW-1:0]    idx_q;
    logic [AW-1:0]    base_q;
    logic [DW-1:0]    snap_q [WORDS];
    logic             count_ok;
    logic             accept;

    // A count is legal only when the whole trigger value is 1..WORDS.
    always_comb begin
        count_ok = (trig_value != '0) && (trig_value <= DW'(WORDS));
        accept   = trig_fire && count_ok && (state_q == SL_IDLE);
    end

    // Control state: request acceptance, frame wait and word stepping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SL_IDLE;
            count_q <= '0;
            idx_q   <= '0;
            base_q  <= '0;
        end else begin
            case (state_q)
                SL_IDLE: begin
                    if (accept) begin
                        state_q <= SL_PEND;
                        count_q <= trig_value[CW-1:0];
                        base_q  <= pointer + AW'(1);
                    end
                end
                SL_PEND: begin
                    if (frame_start) begin
                        state_q <= SL_COPY;
                        idx_q   <= '0;
                    end
                end
                SL_COPY: begin
                    idx_q <= idx_q + CW'(1);
                    if (idx_q == count_q - CW'(1))
                        state_q <= SL_IDLE;
                end
                default: state_q <= SL_IDLE;
            endcase
        end
    end

    // Commit buffer: private copy of every staging word taken at acceptance.
    for (genvar w = 0; w < WORDS; w++) begin : g_snap
        // Hold word w of the accepted request.
        always_ff @(posedge clk) begin
            if (!rst_n)
                snap_q[w] <= '0;
            else if (accept)
                snap_q[w] <= stage_flat[w*DW +: DW];
        end
    end

    // Sticky error for triggers that arrive during a pending or active copy.
    always_ff @(posedge clk) begin
        if (!rst_n)
            err_flag <= 1'b0;
        else if (trig_fire && state_q != SL_IDLE)
            err_flag <= 1'b1;
    end

    // RAM write port and busy flag, decoded from the registered state.
    always_comb begin
        busy      = (state_q != SL_IDLE);
        ram_we    = (state_q == SL_COPY);
        ram_addr  = base_q + AW'(idx_q);
        ram_wdata = '0;
        for (int w = 0; w < WORDS; w++)
            if (idx_q == CW'(w))
                ram_wdata = snap_q[w];
    end
endmodule

// File: rtl/safeload_ctrl.sv
// Top level of the parameter safe-load controller.
// Joins the host register bank to the request sequencer. Assumes frame_start
// is a one-cycle strobe in the clk domain and that the RAM takes one write
// per cycle with no back-pressure.
module safeload_ctrl #(
    parameter int WORDS = 5,
    parameter int DW    = 32,
    parameter int DEPTH = 1024
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          host_wr,
    input  logic [$clog2(WORDS+3)-1:0]    host_reg,
    input  logic [$clog2(DW/8)-1:0]       host_lane,
    input  logic [7:0]                    host_byte,
    input  logic                          frame_start,
    output logic                          busy,
    output logic                          err_flag,
    output logic                          ram_we,
    output logic [$clog2(DEPTH)-1:0]      ram_addr,
    output logic [DW-1:0]                 ram_wdata
);
    localparam int AW = $clog2(DEPTH);

    logic [WORDS*DW-1:0] stage_flat;
    logic [AW-1:0]       pointer;
    logic                trig_fire;
    logic [DW-1:0]       trig_value;

    sload_regfile #(.WORDS(WORDS), .DW(DW), .AW(AW)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (host_wr),
        .wr_reg     (host_reg),
        .wr_lane    (host_lane),
        .wr_byte    (host_byte),
        .stage_flat (stage_flat),
        .pointer    (pointer),
        .trig_fire  (trig_fire),
        .trig_value (trig_value)
    );

    sload_seq #(.WORDS(WORDS), .DW(DW), .AW(AW)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .trig_fire   (trig_fire),
        .trig_value  (trig_value),
        .stage_flat  (stage_flat),
        .pointer     (pointer),
        .frame_start (frame_start),
        .busy        (busy),
        .err_flag    (err_flag),
        .ram_we      (ram_we),
        .ram_addr    (ram_addr),
        .ram_wdata   (ram_wdata)
    );
endmodule

// File: rtl/sload_chk.sv
// Property checker for safeload_ctrl, attached by bind. Observes ports only.
module sload_chk #(
    parameter int WORDS = 5,
    parameter int AW    = 10
) (
    input logic          clk,
    input logic          rst_n,
    input logic          busy,
    input logic          err_flag,
    input logic          ram_we,
    input logic [AW-1:0] ram_addr
);
    localparam int CW = $clog2(WORDS + 2);

    logic [CW-1:0] run_len;

    // Length of the current run of consecutive RAM writes.
    always_ff @(posedge clk) begin
        if (!rst_n)
            run_len <= '0;
        else if (ram_we)
            run_len <= run_len + CW'(1);
        else
            run_len <= '0;
    end

    AST_RESET_QUIET: assert property (@(posedge clk) !rst_n |=> (!busy && !err_flag && !ram_we)); // R1
    AST_WRITE_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n) ram_we |-> busy); // R4
    AST_NO_WRITE_ON_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n) $rose(busy) |-> !ram_we); // R3
    AST_RUN_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n) ram_we |-> (run_len < CW'(WORDS))); // R4
    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_we && $past(ram_we)) |-> (ram_addr == $past(ram_addr) + AW'(1))); // R5
    AST_BUSY_ENDS_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n) $fell(busy) |-> $past(ram_we)); // R8
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n) err_flag |=> err_flag); // R10
endmodule

bind safeload_ctrl sload_chk #(.WORDS(WORDS), .AW($clog2(DEPTH))) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .busy     (busy),
    .err_flag (err_flag),
    .ram_we   (ram_we),
    .ram_addr (ram_addr)
);

// File: tb/safeload_ctrl_tb.sv
module safeload_ctrl_tb;
    localparam int WORDS = 5;
    localparam int DW    = 32;
    localparam int DEPTH = 1024;
    localparam int AW    = 10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          host_wr = 1'b0;
    logic [2:0]    host_reg = '0;
    logic [1:0]    host_lane = '0;
    logic [7:0]    host_byte = '0;
    logic          frame_start = 1'b0;
    logic          busy, err_flag, ram_we;
    logic [AW-1:0] ram_addr;
    logic [DW-1:0] ram_wdata;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    logic [AW-1:0] rec_addr [64];
    logic [DW-1:0] rec_data [64];
    int            rec_n = 0;
    logic [DW-1:0] stage_m [WORDS];

    always #5 clk = ~clk;

    safeload_ctrl #(.WORDS(WORDS), .DW(DW), .DEPTH(DEPTH)) u_dut (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_reg(host_reg),
        .host_lane(host_lane), .host_byte(host_byte), .frame_start(frame_start),
        .busy(busy), .err_flag(err_flag), .ram_we(ram_we),
        .ram_addr(ram_addr), .ram_wdata(ram_wdata)
    );

    // Record every RAM write, sampled mid-cycle.
    always @(negedge clk) begin
        if (ram_we && rec_n < 64) begin
            rec_addr[rec_n] = ram_addr;
            rec_data[rec_n] = ram_wdata;
            rec_n = rec_n + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Expected address of word i (R5).
    function automatic logic [AW-1:0] exp_addr(input logic [DW-1:0] ptr, input int i);
        return AW'(ptr[AW-1:0] + 1 + i);
    endfunction

    task automatic wr_byte(input int r, input int lane, input logic [7:0] b);
        @(negedge clk);
        host_wr = 1'b1; host_reg = 3'(r); host_lane = 2'(lane); host_byte = b;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    // Four byte writes, lane 0 first, most significant byte on lane 0 (R2).
    task automatic wr_reg(input int r, input logic [DW-1:0] v);
        for (int l = 0; l < 4; l++)
            wr_byte(r, l, v[(3-l)*8 +: 8]);
        #1;
    endtask

    task automatic stage_words(input int n);
        for (int i = 0; i < n; i++) begin
            stage_m[i] = $urandom;
            wr_reg(i + 1, stage_m[i]);
        end
    endtask

    task automatic frame_pulse();
        @(negedge clk); frame_start = 1'b1;
        @(negedge clk); frame_start = 1'b0;
        #1;
    endtask

    // Send a frame strobe and compare the burst against the model (R4, R5, R6, R8).
    task automatic commit_and_check(input logic [DW-1:0] ptr, input int cnt, input string tag);
        logic [DW-1:0] exp_w [WORDS];
        for (int i = 0; i < WORDS; i++) exp_w[i] = stage_m[i];
        rec_n = 0;
        frame_pulse();
        for (int i = 0; i < cnt; i++) begin
            @(negedge clk); #1;
        end
        chk(busy == 1'b0, {tag, " R8 busy low after burst"}, 64'(busy), 64'd0);
        chk(rec_n == cnt, {tag, " R4 write count"}, 64'(rec_n), 64'(cnt));
        for (int i = 0; i < cnt && i < rec_n; i++) begin
            chk(rec_addr[i] == exp_addr(ptr, i), {tag, " R5 address"}, 64'(rec_addr[i]), 64'(exp_addr(ptr, i)));
            chk(rec_data[i] == exp_w[i], {tag, " R6 data"}, 64'(rec_data[i]), 64'(exp_w[i]));
        end
    endtask

    // Full request: stage, pointer, trigger, idle wait, frame, compare (R3).
    task automatic transfer(input logic [DW-1:0] ptr, input int cnt, input int gap, input string tag);
        stage_words(WORDS);
        wr_reg(WORDS + 1, ptr);
        rec_n = 0;
        wr_reg(WORDS + 2, DW'(cnt));
        chk(busy == 1'b1, {tag, " R3 busy after trigger"}, 64'(busy), 64'd1);
        for (int g = 0; g < gap; g++) begin
            @(negedge clk); #1;
        end
        chk(rec_n == 0, {tag, " R3 no write before frame"}, 64'(rec_n), 64'd0);
        commit_and_check(ptr, cnt, tag);
    endtask

    initial begin
        void'($urandom(32'h5AFE_10AD));
        repeat (3) @(negedge clk);
        #1;
        chk(!busy && !err_flag && !ram_we, "R1 reset state", {busy, err_flag, ram_we}, 64'd0);
        @(negedge clk); rst_n = 1'b1;

        // R11: frame strobe while idle.
        rec_n = 0;
        frame_pulse(); repeat (3) @(negedge clk); #1;
        chk(rec_n == 0, "R11 idle frame no write", 64'(rec_n), 64'd0);

        // Directed bursts: full, single, wrap across the top, pointer at the last word.
        transfer(32'd100, 5, 2, "full");
        transfer(32'd7, 1, 0, "single");
        transfer(32'd1022, 5, 1, "wrap");
        transfer(32'd1023, 3, 4, "ptr_top");
        transfer(32'hABCD_0010, 2, 1, "ptr_upper_bits");

        // R2: byte lanes land in the expected bit positions.
        stage_m[0] = 32'h1122_3344;
        wr_reg(1, stage_m[0]);
        wr_reg(WORDS + 1, 32'd49);
        wr_reg(WORDS + 2, 32'd1);
        commit_and_check(32'd49, 1, "R2 lane order");

        // R9: illegal counts, including one whose low byte alone looks legal.
        wr_reg(WORDS + 2, 32'd0);
        chk(busy == 1'b0, "R9 count 0 no busy", 64'(busy), 64'd0);
        wr_reg(WORDS + 2, 32'd6);
        chk(busy == 1'b0, "R9 count 6 no busy", 64'(busy), 64'd0);
        wr_reg(WORDS + 2, 32'h0000_0103);
        chk(busy == 1'b0, "R9 upper byte set no busy", 64'(busy), 64'd0);
        rec_n = 0;
        frame_pulse(); repeat (3) @(negedge clk); #1;
        chk(rec_n == 0, "R9 no write after illegal count", 64'(rec_n), 64'd0);
        chk(err_flag == 1'b0, "R9 no error", 64'(err_flag), 64'd0);

        // R7 and R10: rewrites and a second trigger while pending.
        stage_words(WORDS);
        wr_reg(WORDS + 1, 32'd300);
        wr_reg(WORDS + 2, 32'd4);
        begin
            logic [DW-1:0] keep [WORDS];
            for (int i = 0; i < WORDS; i++) keep[i] = stage_m[i];
            wr_reg(1, 32'hDEAD_BEEF);
            wr_reg(WORDS + 1, 32'd600);
            wr_reg(WORDS + 2, 32'd2);
            chk(err_flag == 1'b1, "R10 error on busy trigger", 64'(err_flag), 64'd1);
            chk(busy == 1'b1, "R10 request still pending", 64'(busy), 64'd1);
            for (int i = 0; i < WORDS; i++) stage_m[i] = keep[i];
        end
        commit_and_check(32'd300, 4, "R7 snapshot kept");
        chk(err_flag == 1'b1, "R10 error sticky", 64'(err_flag), 64'd1);

        // Random requests with random pointers, counts and frame delays.
        for (int t = 0; t < 30; t++) begin
            int cnt = 1 + int'($urandom_range(WORDS - 1));
            int gap = int'($urandom_range(6));
            transfer(DW'($urandom), cnt, gap, "random");
        end
        chk(err_flag == 1'b1, "R10 error sticky at end", 64'(err_flag), 64'd1);

        done = 1;
    end

    // Watchdog and summary.
    initial begin
        for (int c = 0; c < 100000 && !done; c++) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=hung expected=done");
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule